// File: doc/BRIEF.md
# Lockable Bus Error Status Register

This block holds the sticky error flags of one bus node in a single 32-bit word that software reaches at offset 0x40 of the node's register window. Error-detection logic elsewhere raises one-cycle pulses on `err_set`. Each pulse on an implemented bit sets that bit, and the bit stays set until software writes a 1 to it.

For diagnostics, `lock_en` turns on a freeze mode. The first qualifying error captured with the mode on freezes the whole word, so the bits set by that first event stay visible. The four syndrome status bits cannot cause the freeze. The freeze ends when software has cleared every bit, or when `lock_en` is withdrawn.

Bit layout:
- [11:0] address and command errors.
- [15:12] correctable and uncorrectable data errors.
- [19:16] syndrome status.
- [21:20] data and address transmitter flags.
- [26:22] fatal data errors.
- [31:27] reserved.

Top module: `bus_err_status`

## Requirements
- R1: After synchronous reset, every bit reads 0, `locked` is 0 and `bus_rdata` is 0.
- R2: While unlocked, a pulse on `err_set[i]` sets implemented bit i from the next edge. The bit stays set with no further pulse.
- R3: A write with `bus_addr` = 0x40 clears each bit whose `bus_wdata` bit is 1 and leaves bits written 0 unchanged. A write to any other address changes nothing.
- R4: While unlocked, a set pulse and a clearing write on the same bit in the same cycle leave the bit set.
- R5: With `lock_en` = 1 and the word unlocked, a pulse on any implemented bit outside [19:16] asserts `locked` from the next edge. Every pulse present in that cycle is captured.
- R6: Pulses confined to the syndrome bits [19:16] never assert `locked`.
- R7: While `locked` is 1, pulses on all bits, syndrome bits included, are ignored.
- R8: Clearing writes take effect while locked. The edge at which the word becomes all zero also drops `locked`.
- R9: When `lock_en` is 0, `locked` is 0 from the next edge, and pulses are captured normally after that.
- R10: Reserved bits [31:27] always read 0, whatever is pulsed or written on them.
- R11: A read with `bus_rd` = 1 returns on `bus_rdata`, one cycle later, the word as it stood before that cycle's edge. A read of any other address, or no read, returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lock_en | input | 1 | Freeze-on-first-error mode enable |
| err_set | input | 32 | One-cycle error pulses, one per bit |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe (write-one-to-clear) |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data, 1 bits select bits to clear |
| bus_rdata | output | 32 | Registered read data |
| locked | output | 1 | Word is frozen |

## Verification
The assertions assume that reset is held at the first clock edges, and that every input is a defined 0 or 1 at each edge. They make no assumption on how pulses, writes and `lock_en` overlap.

The stimulus drives all inputs at the falling edge. It mixes single-bit, multi-bit, syndrome-only and reserved-bit pulses with clearing writes and enable toggles. This puts collisions of pulses, clears and the freeze in the same cycle on purpose.

// File: rtl/ebr_pkg.sv
package ebr_pkg;
  localparam int REG_W  = 32;
  localparam int ADDR_W = 8;
  localparam logic [ADDR_W-1:0] REG_OFFSET = 8'h40;
  // implemented bits: [26:0]; syndrome status bits: [19:16]
  localparam logic [REG_W-1:0] IMPL_MASK = 32'h07FF_FFFF;
  localparam logic [REG_W-1:0] SYND_MASK = 32'h000F_0000;
  typedef logic [REG_W-1:0] word_t;
endpackage

// File: rtl/ebr_port.sv
module ebr_port #(
  parameter int W  = ebr_pkg::REG_W,
  parameter int AW = ebr_pkg::ADDR_W,
  parameter logic [AW-1:0] OFFS = ebr_pkg::REG_OFFSET
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr,
  input  logic          wr,
  input  logic          rd,
  input  logic [W-1:0]  wdata,
  input  logic [W-1:0]  word_q,
  output logic [W-1:0]  clr_vec,
  output logic [W-1:0]  rdata_q
);
  logic hit;

  assign hit     = (addr == OFFS);
  assign clr_vec = (wr && hit) ? wdata : '0;

  // registered read path: value before this cycle's update
  always_ff @(posedge clk) begin
    if (rst)
      rdata_q <= '0;
    else if (rd && hit)
      rdata_q <= word_q;
    else
      rdata_q <= '0;
  end
endmodule

// File: rtl/ebr_bits.sv
module ebr_bits #(
  parameter int W = ebr_pkg::REG_W,
  parameter logic [W-1:0] IMPL = ebr_pkg::IMPL_MASK
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         freeze,
  input  logic [W-1:0] set_in,
  input  logic [W-1:0] clr_in,
  output logic [W-1:0] word_q,
  output logic [W-1:0] word_nxt
);
  logic [W-1:0] kept;

  assign kept = word_q & ~clr_in;

  // new errors win over clears; a frozen word only loses bits
  always_comb begin
    if (freeze)
      word_nxt = kept & IMPL;
    else
      word_nxt = (set_in | kept) & IMPL;
  end

  always_ff @(posedge clk) begin
    if (rst)
      word_q <= '0;
    else
      word_q <= word_nxt;
  end

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (word_q & ~IMPL) == '0); // R10
endmodule

// File: rtl/ebr_lock.sv
module ebr_lock (
  input  logic clk,
  input  logic rst,
  input  logic lock_en,
  input  logic trig,
  input  logic any_nxt,
  output logic lock_q
);
  always_ff @(posedge clk) begin
    if (rst)
      lock_q <= 1'b0;
    else if (!lock_en)
      lock_q <= 1'b0;
    else if (lock_q)
      lock_q <= any_nxt;
    else
      lock_q <= trig;
  end

  AST_EN_DROP_UNLOCKS: assert property (@(posedge clk) disable iff (rst)
    !lock_en |=> !lock_q); // R9
  AST_LOCK_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    $rose(lock_q) |-> $past(lock_en)); // R5
endmodule

// File: rtl/bus_err_status.sv
module bus_err_status #(
  parameter int W  = ebr_pkg::REG_W,
  parameter int AW = ebr_pkg::ADDR_W,
  parameter logic [AW-1:0] OFFS = ebr_pkg::REG_OFFSET,
  parameter logic [W-1:0]  IMPL = ebr_pkg::IMPL_MASK,
  parameter logic [W-1:0]  SYND = ebr_pkg::SYND_MASK
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          lock_en,
  input  logic [W-1:0]  err_set,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  output logic          locked
);
  localparam logic [W-1:0] LOCKABLE = IMPL & ~SYND;

  logic [W-1:0] word_q, word_nxt, clr_vec;
  logic         lock_q, trig;

  assign trig   = |(err_set & LOCKABLE);
  assign locked = lock_q;

  ebr_port #(.W(W), .AW(AW), .OFFS(OFFS)) u_port (
    .clk(clk), .rst(rst), .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
    .wdata(bus_wdata), .word_q(word_q), .clr_vec(clr_vec), .rdata_q(bus_rdata)
  );

  ebr_bits #(.W(W), .IMPL(IMPL)) u_bits (
    .clk(clk), .rst(rst), .freeze(lock_q), .set_in(err_set), .clr_in(clr_vec),
    .word_q(word_q), .word_nxt(word_nxt)
  );

  ebr_lock u_lock (
    .clk(clk), .rst(rst), .lock_en(lock_en), .trig(trig),
    .any_nxt(|word_nxt), .lock_q(lock_q)
  );

  AST_FROZEN_NO_SET: assert property (@(posedge clk) disable iff (rst)
    lock_q |=> ((word_q & ~$past(word_q)) == '0)); // R7
  AST_LOCK_HAS_BITS: assert property (@(posedge clk) disable iff (rst)
    lock_q |-> (word_q != '0)); // R8
  AST_SYND_NO_LOCK: assert property (@(posedge clk) disable iff (rst)
    (!lock_q && ((err_set & LOCKABLE) == '0)) |=> !lock_q); // R6
endmodule

// File: tb/sim_bus_err_status.sv
`timescale 1ns/1ps
module sim_bus_err_status;
  localparam logic [31:0] IMPL = 32'h07FF_FFFF;
  localparam logic [31:0] SYND = 32'h000F_0000;
  localparam logic [7:0]  OFFS = 8'h40;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lock_en = 1'b0;
  logic [31:0] err_set = '0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        locked;

  int errors = 0;
  int checks = 0;
  logic [31:0] mb = '0;
  logic        ml = 1'b0;
  logic        done = 1'b0;

  always #2 clk = ~clk;

  bus_err_status u0 (
    .clk(clk), .rst(rst), .lock_en(lock_en), .err_set(err_set),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .locked(locked)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one clock: drive at falling edge, update the model at the rising edge,
  // compare shortly after it
  task automatic step(input string tag, input logic [31:0] s, input logic en,
                      input logic w, input logic r, input logic [7:0] a,
                      input logic [31:0] wd);
    logic [31:0] clr, exp_r, nb;
    logic        nl;
    @(negedge clk);
    err_set = s; lock_en = en; bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = wd;
    @(posedge clk);
    clr   = (w && a == OFFS) ? wd : 32'h0;
    exp_r = (r && a == OFFS) ? mb : 32'h0;
    if (ml) nb = mb & ~clr & IMPL;
    else    nb = ((s & IMPL) | (mb & ~clr)) & IMPL;
    if (!en)     nl = 1'b0;
    else if (ml) nl = (nb != 0);
    else         nl = ((s & IMPL & ~SYND) != 0);
    mb = nb; ml = nl;
    #1;
    chk({tag, " rdata"}, bus_rdata, exp_r);
    chk({tag, " locked"}, {31'b0, locked}, {31'b0, ml});
  endtask

  task automatic pulse(input string tag, input logic [31:0] s, input logic en);
    step(tag, s, en, 1'b0, 1'b0, OFFS, 32'h0);
  endtask
  task automatic wclr(input string tag, input logic [7:0] a, input logic [31:0] wd, input logic en);
    step(tag, 32'h0, en, 1'b1, 1'b0, a, wd);
  endtask
  // read, then compare the returned word with a fixed expectation
  task automatic rdlit(input string tag, input logic [31:0] lit, input logic en);
    step(tag, 32'h0, en, 1'b0, 1'b1, OFFS, 32'h0);
    chk({tag, " literal"}, bus_rdata, lit);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 rdata", bus_rdata, 32'h0);
    chk("R1 locked", {31'b0, locked}, 32'h0);
    @(negedge clk); rst = 1'b0;
    rdlit("R1", 32'h0, 1'b0);

    pulse("R2", 32'h0000_0008, 1'b0);
    pulse("R2", 32'h0000_3000, 1'b0);
    rdlit("R2", 32'h0000_3008, 1'b0);
    wclr("R3", 8'h44, 32'h0000_0008, 1'b0);
    rdlit("R3", 32'h0000_3008, 1'b0);
    wclr("R3", OFFS, 32'h0000_0008, 1'b0);
    wclr("R3", OFFS, 32'h0000_0000, 1'b0);
    rdlit("R3", 32'h0000_3000, 1'b0);
    step("R4", 32'h0000_1000, 1'b0, 1'b1, 1'b0, OFFS, 32'h0000_3000);
    rdlit("R4", 32'h0000_1000, 1'b0);
    wclr("R3", OFFS, 32'hFFFF_FFFF, 1'b0);

    pulse("R6", 32'h000F_0000, 1'b1);
    chk("R6 lock", {31'b0, locked}, 32'h0);
    rdlit("R6", 32'h000F_0000, 1'b1);
    pulse("R5", 32'h0050_0001, 1'b1);
    chk("R5 lock", {31'b0, locked}, 32'h1);
    rdlit("R5", 32'h005F_0001, 1'b1);
    pulse("R7", 32'h0000_0002, 1'b1);
    pulse("R7", 32'h0000_0000, 1'b1);
    rdlit("R7", 32'h005F_0001, 1'b1);
    wclr("R8", OFFS, 32'h000A_0000, 1'b1);
    pulse("R7", 32'h000A_0000, 1'b1);
    rdlit("R8", 32'h0055_0001, 1'b1);
    wclr("R8", OFFS, 32'h0040_0001, 1'b1);
    chk("R8 still", {31'b0, locked}, 32'h1);
    wclr("R8", OFFS, 32'h0015_0000, 1'b1);
    chk("R8 unlock", {31'b0, locked}, 32'h0);
    pulse("R8", 32'h0000_0010, 1'b1);
    chk("R8 relock", {31'b0, locked}, 32'h1);
    pulse("R9", 32'h0000_0000, 1'b0);
    chk("R9 unlock", {31'b0, locked}, 32'h0);
    pulse("R9", 32'h0000_0020, 1'b0);
    rdlit("R9", 32'h0000_0030, 1'b0);
    wclr("R9", OFFS, 32'hFFFF_FFFF, 1'b0);

    pulse("R10", 32'hF800_0000, 1'b1);
    wclr("R10", OFFS, 32'hF800_0000, 1'b1);
    rdlit("R10", 32'h0000_0000, 1'b1);
    pulse("R2", 32'h0000_0100, 1'b0);
    step("R11", 32'h0, 1'b0, 1'b0, 1'b1, 8'h48, 32'h0);
    chk("R11 other addr", bus_rdata, 32'h0);
    step("R11", 32'h0, 1'b0, 1'b0, 1'b0, OFFS, 32'h0);
    chk("R11 no read", bus_rdata, 32'h0);
    rdlit("R11", 32'h0000_0100, 1'b0);

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] s, wd;
      logic        en, w;
      logic [7:0]  a;
      case ($urandom % 4)
        0: s = 32'h1 << ($urandom % 32);
        1: s = $urandom & SYND;
        2: s = $urandom;
        default: s = 32'h0;
      endcase
      en = (($urandom % 8) != 0);
      w  = (($urandom % 3) == 0);
      wd = (($urandom % 2) == 0) ? 32'hFFFF_FFFF : $urandom;
      a  = (($urandom % 6) == 0) ? 8'h3C : OFFS;
      step("R2 R5 R7 R8 R9 mixed", s, en, w, 1'b1, a, wd);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule